// File: doc/BRIEF.md
# In-Order Three-Way Instruction Dispatcher

This block accepts a stream of instructions through a valid/ready input and keeps them in one shared first-in first-out queue. Each cycle it examines the oldest queued instruction and decodes its two-bit class field. It then moves that instruction into a one-entry holding slot that belongs to the integer, floating-point or load-store execution unit. Each unit takes instructions from its own slot through a separate valid/ready handshake, at whatever rate it can manage. Several units can therefore be busy at the same time.

Issue is strictly in order. When the oldest instruction is meant for a unit whose slot is still occupied, it stays at the head of the queue, and nothing behind it moves. This holds even when the instruction behind it targets an idle unit. The slots that are already filled still drain at their units' own rates. A trace timer and a completed-instruction counter let a surrounding model measure how long a sequence of instructions takes to pass through the units. Timing starts with the first enqueue and ends when everything has drained and the units report that they are idle.

Top module: `insn_dispatch`

## Requirements
- R1: The class field is bits [1:0]. Class 00 is routed to the integer unit, 01 to the floating-point unit and 10 to the load-store unit. The reserved class 11 is routed to the integer unit. The full instruction word reaches the unit unchanged.
- R2: Each unit receives the instructions of its class in the order in which they were enqueued, with none lost and none duplicated.
- R3: The shared queue holds 8 instructions. `in_ready` is low while it holds 8, and no enqueue is taken during that time. An instruction presented while the queue is full is accepted once space frees, in its correct order.
- R4: If the head instruction targets a slot that is occupied and not being drained this cycle, nothing is dispatched. Later instructions for idle units wait behind it.
- R5: A filled slot keeps its valid and its instruction stable until its unit accepts. Each slot drains independently of the other slots and of the queue head.
- R6: At most one instruction is dispatched per cycle. An instruction accepted at clock edge k is presented to its unit after edge k+1. A slot drained in a cycle can be reloaded in that same cycle, so a same-class stream moves one instruction per cycle.
- R7: While the floating-point slot is valid, `fp_op` shows its bits [4:2] (0 add, 1 subtract, 2 compare, 3 multiply, 4 multiply-add, 5 divide) and `fp_dbl` shows its bit 5 (1 = double precision).
- R8: `done_cnt` increases by the number of unit handshakes (valid and ready both high) in each cycle.
- R9: `trace_active` is set by an enqueue. `trace_cycles` counts every cycle in which `trace_active` is high. `trace_active` clears after a cycle with an empty queue, empty slots, `units_idle` high and no enqueue. The count is then held. For N back-to-back integer instructions to an always-ready unit, the count is N+2.
- R10: Reset empties the queue and the slots and clears both counters. After reset, `in_ready` is 1, all unit valids are 0 and `trace_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered to the queue |
| in_ready | output | 1 | Queue has space |
| in_insn | input | W | Instruction word, class in bits [1:0] |
| units_idle | input | 1 | All execution units have finished their work |
| int_valid | output | 1 | Integer slot holds an instruction |
| int_ready | input | 1 | Integer unit takes the instruction |
| int_insn | output | W | Integer slot contents |
| fp_valid | output | 1 | Floating-point slot holds an instruction |
| fp_ready | input | 1 | Floating-point unit takes the instruction |
| fp_insn | output | W | Floating-point slot contents |
| fp_op | output | 3 | Decoded floating-point operation |
| fp_dbl | output | 1 | Decoded precision, 1 = double |
| ls_valid | output | 1 | Load-store slot holds an instruction |
| ls_ready | input | 1 | Load-store unit takes the instruction |
| ls_insn | output | W | Load-store slot contents |
| done_cnt | output | CNT_W | Instructions handed to the units |
| trace_active | output | 1 | Trace timer is running |
| trace_cycles | output | CNT_W | Accumulated trace time in cycles |

## Verification
Some properties are checked on every cycle. The queue never exceeds its depth, and at most one slot loads per cycle. A blocked head instruction never causes a load. A stalled slot keeps its contents. The completed counter tracks the handshakes exactly, and an enqueue always starts the timer.

Other properties can only be shown by the bench's scenarios. These are the routing of each class, including the reserved one, and the per-unit ordering under mixed ready rates. They also include the one-cycle dispatch latency and the exact trace-time values, such as N+2 for a stream and the extension caused by a busy `units_idle`. The bench also shows that an instruction offered to a full queue arrives later in its correct position.

// File: rtl/insn_dispatch_pkg.sv
package insn_dispatch_pkg;

    localparam int NUM_UNITS  = 3;
    localparam int UNIT_INT   = 0;
    localparam int UNIT_FP    = 1;
    localparam int UNIT_LS    = 2;

    localparam int CLS_LSB    = 0;
    localparam int CLS_W      = 2;
    localparam int FP_OP_LSB  = 2;
    localparam int FP_OP_W    = 3;
    localparam int FP_DBL_BIT = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_INT = 2'b00,
        CLS_FP  = 2'b01,
        CLS_LS  = 2'b10,
        CLS_RSV = 2'b11
    } insn_cls_e;

    // One-hot unit selection for a class code; reserved code goes to integer.
    function automatic logic [NUM_UNITS-1:0] cls_to_sel(input logic [CLS_W-1:0] code);
        logic [NUM_UNITS-1:0] sel;
        sel = '0;
        case (insn_cls_e'(code))
            CLS_FP:  sel[UNIT_FP]  = 1'b1;
            CLS_LS:  sel[UNIT_LS]  = 1'b1;
            default: sel[UNIT_INT] = 1'b1;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/dispatch_fifo.sv
module dispatch_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_valid,
    output logic                         push_ready,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic                         head_valid,
    output logic [W-1:0]                 head_data,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [LW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_valid && push_ready;
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + LW'(1);
            2'b01:   st_d.cnt = st_q.cnt - LW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_ready = (st_q.cnt != LW'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];
    assign level      = st_q.cnt;

endmodule

// File: rtl/unit_slot.sv
module unit_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         free_o
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.vld  = 1'b1;
            st_d.data = data_i;
        end else if (st_q.vld && ready_i) begin
            st_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.vld;
    assign data_o  = st_q.data;
    // Free when empty or when the unit takes the current entry this cycle.
    assign free_o  = !st_q.vld || ready_i;

endmodule

// File: rtl/trace_timer.sv
module trace_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             busy_i,
    input  logic             idle_i,
    input  logic [1:0]       hs_cnt_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cycles_o,
    output logic [CNT_W-1:0] done_o
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cycles;
        logic [CNT_W-1:0] done;
    } timer_st_t;

    timer_st_t st_d, st_q;
    logic      quiet;

    always_comb begin
        st_d  = st_q;
        quiet = !busy_i && idle_i && !push_i;
        st_d.done = st_q.done + CNT_W'(hs_cnt_i);
        if (st_q.active) begin
            st_d.cycles = st_q.cycles + CNT_W'(1);
        end
        st_d.active = push_i || (st_q.active && !quiet);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign cycles_o = st_q.cycles;
    assign done_o   = st_q.done;

endmodule

// File: rtl/insn_dispatch.sv
module insn_dispatch
    import insn_dispatch_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     in_insn,
    input  logic             units_idle,
    output logic             int_valid,
    input  logic             int_ready,
    output logic [W-1:0]     int_insn,
    output logic             fp_valid,
    input  logic             fp_ready,
    output logic [W-1:0]     fp_insn,
    output logic [2:0]       fp_op,
    output logic             fp_dbl,
    output logic             ls_valid,
    input  logic             ls_ready,
    output logic [W-1:0]     ls_insn,
    output logic [CNT_W-1:0] done_cnt,
    output logic             trace_active,
    output logic [CNT_W-1:0] trace_cycles
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    logic                           head_valid;
    logic [W-1:0]                   head_data;
    logic [LVL_W-1:0]               fifo_level;
    logic [NUM_UNITS-1:0]           head_sel;
    logic [NUM_UNITS-1:0]           slot_vld;
    logic [NUM_UNITS-1:0]           slot_rdy;
    logic [NUM_UNITS-1:0]           slot_free;
    logic [NUM_UNITS-1:0]           slot_load;
    logic [NUM_UNITS-1:0][W-1:0]    slot_data;
    logic                           dispatch;
    logic [1:0]                     hs_cnt;
    logic                           busy;

    dispatch_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_ready (in_ready),
        .push_data  (in_insn),
        .pop        (dispatch),
        .head_valid (head_valid),
        .head_data  (head_data),
        .level      (fifo_level)
    );

    assign slot_rdy[UNIT_INT] = int_ready;
    assign slot_rdy[UNIT_FP]  = fp_ready;
    assign slot_rdy[UNIT_LS]  = ls_ready;

    // Head decode and in-order issue: only the head may move.
    always_comb begin
        head_sel  = head_valid ? cls_to_sel(head_data[CLS_LSB +: CLS_W]) : '0;
        dispatch  = |(head_sel & slot_free);
        slot_load = dispatch ? head_sel : '0;
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
        unit_slot #(.W(W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (slot_load[u]),
            .data_i  (head_data),
            .ready_i (slot_rdy[u]),
            .valid_o (slot_vld[u]),
            .data_o  (slot_data[u]),
            .free_o  (slot_free[u])
        );
    end

    always_comb begin
        hs_cnt = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            hs_cnt = hs_cnt + 2'(slot_vld[u] && slot_rdy[u]);
        end
        busy = head_valid || (|slot_vld);
    end

    trace_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (in_valid && in_ready),
        .busy_i   (busy),
        .idle_i   (units_idle),
        .hs_cnt_i (hs_cnt),
        .active_o (trace_active),
        .cycles_o (trace_cycles),
        .done_o   (done_cnt)
    );

    assign int_valid = slot_vld[UNIT_INT];
    assign int_insn  = slot_data[UNIT_INT];
    assign fp_valid  = slot_vld[UNIT_FP];
    assign fp_insn   = slot_data[UNIT_FP];
    assign fp_op     = slot_data[UNIT_FP][FP_OP_LSB +: FP_OP_W];
    assign fp_dbl    = slot_data[UNIT_FP][FP_DBL_BIT];
    assign ls_valid  = slot_vld[UNIT_LS];
    assign ls_insn   = slot_data[UNIT_LS];

endmodule

// File: rtl/insn_dispatch_chk.sv
module insn_dispatch_chk #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int CNT_W = 16,
    parameter int LVL_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [LVL_W-1:0]      fifo_level,
    input logic                  head_valid,
    input logic [2:0]            head_sel,
    input logic [2:0]            slot_vld,
    input logic [2:0]            slot_rdy,
    input logic [2:0]            slot_load,
    input logic [2:0][W-1:0]     slot_data,
    input logic [CNT_W-1:0]      done_cnt,
    input logic                  trace_active
);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R3
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH)) |-> !in_ready);

    // R6
    one_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_load));

    // R4
    head_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && |(head_sel & slot_vld & ~slot_rdy)) |-> (slot_load == 3'b000));

    // R5
    int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[0] && !slot_rdy[0]) |=> (slot_vld[0] && $stable(slot_data[0])));

    // R5
    fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[1] && !slot_rdy[1]) |=> (slot_vld[1] && $stable(slot_data[1])));

    // R5
    ls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[2] && !slot_rdy[2]) |=> (slot_vld[2] && $stable(slot_data[2])));

    // R8
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_cnt == CNT_W'($past(done_cnt) + CNT_W'($countones($past(slot_vld & slot_rdy))))));

    // R9
    trace_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> trace_active);

endmodule

bind insn_dispatch insn_dispatch_chk #(
    .W     (W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .LVL_W (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .fifo_level   (fifo_level),
    .head_valid   (head_valid),
    .head_sel     (head_sel),
    .slot_vld     (slot_vld),
    .slot_rdy     (slot_rdy),
    .slot_load    (slot_load),
    .slot_data    (slot_data),
    .done_cnt     (done_cnt),
    .trace_active (trace_active)
);

// File: tb/insn_dispatch_bench.sv
module insn_dispatch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int DEPTH      = 8;
    localparam int CNT_W      = 16;
    localparam int LOG_N      = 64;

    logic             clk;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic [W-1:0]     in_insn;
    logic             units_idle;
    logic             int_valid, int_ready;
    logic [W-1:0]     int_insn;
    logic             fp_valid, fp_ready;
    logic [W-1:0]     fp_insn;
    logic [2:0]       fp_op;
    logic             fp_dbl;
    logic             ls_valid, ls_ready;
    logic [W-1:0]     ls_insn;
    logic [CNT_W-1:0] done_cnt;
    logic             trace_active;
    logic [CNT_W-1:0] trace_cycles;

    insn_dispatch #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_insn_dispatch (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
        .units_idle(units_idle),
        .int_valid(int_valid), .int_ready(int_ready), .int_insn(int_insn),
        .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_insn(fp_insn),
        .fp_op(fp_op), .fp_dbl(fp_dbl),
        .ls_valid(ls_valid), .ls_ready(ls_ready), .ls_insn(ls_insn),
        .done_cnt(done_cnt), .trace_active(trace_active), .trace_cycles(trace_cycles)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int rmode [3];
    int n_pushed;

    logic [W-1:0] lg  [3][LOG_N];
    int           lgn [3];
    logic [2:0]   lg_op  [LOG_N];
    logic         lg_dbl [LOG_N];
    logic [W-1:0] ex  [3][LOG_N];
    int           exn [3];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic rdy_of(input int m, input int c);
        case (m)
            0:       return 1'b1;
            1:       return 1'b0;
            2:       return c[0];
            default: return (c % 3) == 0;
        endcase
    endfunction

    function automatic int unit_of(input logic [W-1:0] x);
        if (x[1:0] == 2'b01) return 1;
        if (x[1:0] == 2'b10) return 2;
        return 0;
    endfunction

    // Unit sink models: pick ready at the falling edge, log handshakes just after.
    always @(negedge clk) begin
        cyc++;
        int_ready = rdy_of(rmode[0], cyc);
        fp_ready  = rdy_of(rmode[1], cyc + 1);
        ls_ready  = rdy_of(rmode[2], cyc + 2);
        #1;
        if (rst_n) begin
            if (int_valid && int_ready && lgn[0] < LOG_N) begin
                lg[0][lgn[0]] = int_insn; lgn[0]++;
            end
            if (fp_valid && fp_ready && lgn[1] < LOG_N) begin
                lg[1][lgn[1]] = fp_insn; lg_op[lgn[1]] = fp_op; lg_dbl[lgn[1]] = fp_dbl; lgn[1]++;
            end
            if (ls_valid && ls_ready && lgn[2] < LOG_N) begin
                lg[2][lgn[2]] = ls_insn; lgn[2]++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; units_idle = 1'b1;
        for (int u = 0; u < 3; u++) begin lgn[u] = 0; exn[u] = 0; end
        n_pushed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [W-1:0] x);
        int u;
        @(negedge clk);
        in_valid = 1'b1; in_insn = x;
        u = unit_of(x);
        if (exn[u] < LOG_N) begin ex[u][exn[u]] = x; exn[u]++; end
        n_pushed++;
        #2;
        while (!in_ready) begin @(negedge clk); #2; end
        @(posedge clk);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0;
        #2;
    endtask

    task automatic wait_done(input int n);
        int k = 0;
        while (done_cnt != CNT_W'(n) && k < 600) begin @(negedge clk); k++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_logs(input string tag);
        for (int u = 0; u < 3; u++) begin
            chk({tag, " R2 count"}, lgn[u], exn[u]);
            for (int i = 0; i < exn[u] && i < lgn[u]; i++)
                chk({tag, " R1/R2 word"}, lg[u][i], ex[u][i]);
        end
        for (int i = 0; i < exn[1] && i < lgn[1]; i++) begin
            chk({tag, " R7 op"},  lg_op[i],  ex[1][i][4:2]);
            chk({tag, " R7 dbl"}, lg_dbl[i], ex[1][i][5]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int modes [3];
        modes[0] = 0; modes[1] = 2; modes[2] = 3;
        rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; units_idle = 1'b1;
        int_ready = 1'b0; fp_ready = 1'b0; ls_ready = 1'b0;
        for (int u = 0; u < 3; u++) rmode[u] = 0;

        // R10: reset state
        do_reset();
        #2;
        chk("R10 in_ready", in_ready, 1);
        chk("R10 valids", {int_valid, fp_valid, ls_valid}, 0);
        chk("R10 done_cnt", done_cnt, 0);
        chk("R10 trace_cycles", trace_cycles, 0);
        chk("R10 trace_active", trace_active, 0);

        // R6 latency and R9 single instruction (N=1 gives 3)
        push(16'h0040);
        idle_in();
        chk("R6 not yet presented", int_valid, 0);
        @(negedge clk); #2;
        chk("R6 presented after one edge", int_valid, 1);
        repeat (8) @(negedge clk);
        chk("R9 single trace", trace_cycles, 3);
        chk("R8 single done", done_cnt, 1);
        compare_logs("single");

        // R9 / R6: back-to-back streams sustain one per cycle, count N+2
        for (int n = 2; n <= 5; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) push(W'((i << 6) | 2'b00));
            idle_in();
            repeat (10) @(negedge clk);
            chk("R9 stream trace", trace_cycles, n + 2);
            chk("R9 stream stopped", trace_active, 0);
            chk("R8 stream done", done_cnt, n);
            repeat (5) @(negedge clk);
            chk("R9 trace held", trace_cycles, n + 2);
        end

        // R9: units_idle low keeps the timer running
        do_reset();
        units_idle = 1'b0;
        push(16'h0080);
        idle_in();
        repeat (3) @(negedge clk);
        #2;
        chk("R9 active while units busy", trace_active, 1);
        @(negedge clk);
        units_idle = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 trace extended", trace_cycles, 5);

        // R4: head blocked on full FP slot stalls int and ls behind it
        do_reset();
        rmode[0] = 0; rmode[1] = 1; rmode[2] = 0;
        push(16'h0105); push(16'h023D); push(16'h0300); push(16'h0402);
        idle_in();
        repeat (8) @(negedge clk);
        #2;
        chk("R4 int waits behind head", lgn[0], 0);
        chk("R4 ls waits behind head", lgn[2], 0);
        chk("R4 fp slot held", fp_valid, 1);
        rmode[1] = 0;
        wait_done(4);
        compare_logs("R4 block");

        // R5: stuck integer slot does not hold back a floating-point slot
        do_reset();
        rmode[0] = 1; rmode[1] = 0; rmode[2] = 0;
        push(16'h0500); push(16'h0611);
        idle_in();
        repeat (6) @(negedge clk);
        #2;
        chk("R5 fp drained independently", lgn[1], 1);
        chk("R5 int still held", int_valid, 1);
        chk("R5 int not taken", lgn[0], 0);
        rmode[0] = 0;
        wait_done(2);
        compare_logs("R5 indep");

        // R3: full queue refuses, late entry keeps its order
        do_reset();
        rmode[0] = 1; rmode[1] = 1; rmode[2] = 1;
        for (int i = 0; i < 9; i++) push(W'(((i + 1) << 6) | 2'b00));
        @(negedge clk); #2;
        chk("R3 full in_ready", in_ready, 0);
        fork
            push(16'h3FC0);
            begin
                repeat (4) @(negedge clk);
                #2;
                chk("R3 still refused", in_ready, 0);
                chk("R3 nothing consumed", lgn[0], 0);
                rmode[0] = 0;
            end
        join
        idle_in();
        wait_done(10);
        compare_logs("R3 full");
        chk("R8 full done", done_cnt, 10);

        // R1/R2/R7/R8: sweep over ready-rate combinations and mixed classes
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++) begin
                    int combo;
                    combo = a * 9 + b * 3 + c;
                    do_reset();
                    rmode[0] = modes[a]; rmode[1] = modes[b]; rmode[2] = modes[c];
                    for (int i = 0; i < 24; i++) begin
                        logic [1:0] cls;
                        logic [3:0] f;
                        logic [9:0] tag;
                        cls = 2'((i * 5 + combo + i / 3) % 4);
                        f   = 4'((i * 3 + combo) % 16);
                        tag = 10'(i + combo * 32);
                        push({tag, f, cls});
                    end
                    idle_in();
                    wait_done(24);
                    compare_logs("sweep");
                    chk("R8 sweep done", done_cnt, 24);
                end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule